// File: doc/BRIEF.md
# Pipeline Hazard Stall/Bubble Controller

This block decides, every cycle, how each of the five pipeline registers of an in-order pipeline behaves. The registers are Fetch, Decode, Execute, Memory and Write-back. Each register either loads normally, holds its value (stall) or loads a no-op (bubble). The block also decides whether the execute stage may update the condition codes. It reads only the instruction codes held in the Decode, Execute and Memory stages and the memory destination register of the instruction in Execute. It also reads the two register sources being decoded, the branch outcome computed in Execute, and the status codes of the Memory and Write-back stages. All control outputs are combinational, so the surrounding pipeline uses them at the same clock edge.

Four hazard conditions are detected: a load followed by a use of its result, a return travelling down the pipeline, a conditional jump that was wrongly predicted taken, and a fault status reaching the back of the pipe. When several conditions hold at once, they are merged so that no register ever receives stall and bubble together. A stall request on a register overrides a bubble request on that same register, which gives the load/use hazard priority over return processing in Decode. The project also holds a parameterised pipeline register. Its three modes match the controls this block produces, and its reset loads the no-op value.

Top module: `hzc_stage_ctl`

## Requirements
- R1: When the Execute opcode is a load (0x5) or a pop (0xB), and its memory destination equals `dec_src_a` or `dec_src_b`, the outputs are stall on F (bit 0) and D (bit 1) and bubble on E (bit 2).
- R2: A memory destination of 0xF never produces a load/use hazard, even when a decode source is also 0xF.
- R3: While a return opcode (0x9) sits in D, E or M and there is no load/use hazard, F is stalled and D is bubbled.
- R4: A jump opcode (0x7) in Execute with `exe_cond_ok` = 0 bubbles D and E. The same jump with `exe_cond_ok` = 1 causes no action.
- R5: When `mem_status` or `wb_status` is address error (1), invalid instruction (2) or halt (3), M is bubbled (bit 3) and W is stalled (bit 4). Status OK (0) on both causes no action.
- R6: `cc_wr_en` is 1 exactly when the Execute opcode is an ALU operation (0x6) and both `mem_status` and `wb_status` are OK.
- R7: When a load/use hazard and return processing coincide, the result is F stall, D stall and E bubble, with D bubble held at 0.
- R8: A wrongly predicted jump in E together with a return in D gives F stall, D bubble and E bubble.
- R9: E stall, M stall, F bubble and W bubble are always 0. With no hazard condition, every stall and bubble output is 0.
- R10: No stage ever has its stall and bubble outputs asserted together.
- R11: With stall and bubble both low, the pipeline register loads its input on the rising clock.
- R12: The pipeline register holds its value under stall and loads the no-op value under bubble. When both are high, stall wins and the value is held.
- R13: While the active-low reset is low at a rising clock, the pipeline register loads the no-op value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dec_op | input | IW (4) | Opcode of the instruction in Decode |
| exe_op | input | IW (4) | Opcode of the instruction in Execute |
| mem_op | input | IW (4) | Opcode of the instruction in Memory |
| exe_ld_dst | input | RW (4) | Memory destination register of the Execute instruction, 0xF for none |
| dec_src_a | input | RW (4) | First source register being decoded |
| dec_src_b | input | RW (4) | Second source register being decoded |
| exe_cond_ok | input | 1 | Branch condition evaluated in Execute |
| mem_status | input | 2 | Status code leaving the Memory stage |
| wb_status | input | 2 | Status code held in Write-back |
| stage_stall | output | 5 | Stall per register, bit 0 = F to bit 4 = W |
| stage_bubble | output | 5 | Bubble per register, bit 0 = F to bit 4 = W |
| cc_wr_en | output | 1 | Condition-code write enable for Execute |

## Verification
The bound checker evaluates the controller's combinational outputs continuously. It checks that no stage gets stall and bubble together, that each detected condition produces its stage actions, that the condition codes are gated by fault status, and that the four never-used control lines stay low. Some properties are not expressed as assertions: the exact merged result of coinciding conditions (load/use with return, misprediction with return), the absence of any action when a condition narrowly misses, and the clocked behaviour of the pipeline register. These are shown only by the bench's directed and randomised scenarios, which compare every output against a behavioural model.

// File: rtl/hzc_pkg.sv
// Shared constants and helpers for the stage controller.
// Assumes five pipeline registers indexed F=0 .. W=4 and four hazard causes.
package hzc_pkg;

    localparam int STG_N = 5;
    localparam int STG_F = 0;
    localparam int STG_D = 1;
    localparam int STG_E = 2;
    localparam int STG_M = 3;
    localparam int STG_W = 4;

    // hazard cause bit positions
    localparam int HZ_N        = 4;
    localparam int HZ_LOAD_USE = 0;
    localparam int HZ_RET      = 1;
    localparam int HZ_MISPRED  = 2;
    localparam int HZ_FAULT    = 3;

    typedef enum logic [1:0] {
        ST_OK  = 2'd0,
        ST_ADR = 2'd1,
        ST_INS = 2'd2,
        ST_HLT = 2'd3
    } stat_e;

    // Any non-OK status stops the pipeline.
    function automatic logic stat_is_fault(input logic [1:0] s);
        return s != ST_OK;
    endfunction

    // Causes that request a stall of stage s.
    function automatic logic [HZ_N-1:0] stall_mask(input int s);
        logic [HZ_N-1:0] m;
        m = '0;
        case (s)
            STG_F: begin
                m[HZ_LOAD_USE] = 1'b1;
                m[HZ_RET]      = 1'b1;
            end
            STG_D:   m[HZ_LOAD_USE] = 1'b1;
            STG_W:   m[HZ_FAULT]    = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // Causes that request a bubble into stage s.
    function automatic logic [HZ_N-1:0] bubble_mask(input int s);
        logic [HZ_N-1:0] m;
        m = '0;
        case (s)
            STG_D: begin
                m[HZ_RET]     = 1'b1;
                m[HZ_MISPRED] = 1'b1;
            end
            STG_E: begin
                m[HZ_LOAD_USE] = 1'b1;
                m[HZ_MISPRED]  = 1'b1;
            end
            STG_M:   m[HZ_FAULT] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hzc_detect.sv
// Hazard detector: turns stage opcodes, register IDs, branch outcome and
// status codes into a vector of hazard causes plus an "ALU op in E" flag.
// Assumes REG_NONE marks an instruction without a memory destination.
module hzc_detect
    import hzc_pkg::*;
#(
    parameter int             IW       = 4,
    parameter int             RW       = 4,
    parameter logic [IW-1:0]  OP_LOAD  = 'h5,
    parameter logic [IW-1:0]  OP_POP   = 'hB,
    parameter logic [IW-1:0]  OP_RET   = 'h9,
    parameter logic [IW-1:0]  OP_JMP   = 'h7,
    parameter logic [IW-1:0]  OP_ALU   = 'h6,
    parameter logic [RW-1:0]  REG_NONE = '1
) (
    input  logic [IW-1:0]   dec_op,
    input  logic [IW-1:0]   exe_op,
    input  logic [IW-1:0]   mem_op,
    input  logic [RW-1:0]   exe_ld_dst,
    input  logic [RW-1:0]   dec_src_a,
    input  logic [RW-1:0]   dec_src_b,
    input  logic            exe_cond_ok,
    input  logic [1:0]      mem_status,
    input  logic [1:0]      wb_status,
    output logic [HZ_N-1:0] cause,
    output logic            exe_alu
);

    localparam int RET_SLOTS = 3;

    logic [RET_SLOTS-1:0][IW-1:0] ret_scan;
    logic                         ret_hit;
    logic                         exe_loads;
    logic                         dst_match;

    assign ret_scan = {mem_op, exe_op, dec_op};

    // Look for a return in any of the three scanned stages.
    always_comb begin
        ret_hit = 1'b0;
        for (int i = 0; i < RET_SLOTS; i++) begin
            if (ret_scan[i] == OP_RET) ret_hit = 1'b1;
        end
    end

    // Decide whether the E instruction writes a register a decode source needs.
    always_comb begin
        exe_loads = (exe_op == OP_LOAD) || (exe_op == OP_POP);
        dst_match = (exe_ld_dst != REG_NONE) &&
                    ((exe_ld_dst == dec_src_a) || (exe_ld_dst == dec_src_b));
    end

    // Assemble the cause vector.
    always_comb begin
        cause              = '0;
        cause[HZ_LOAD_USE] = exe_loads && dst_match;
        cause[HZ_RET]      = ret_hit;
        cause[HZ_MISPRED]  = (exe_op == OP_JMP) && !exe_cond_ok;
        cause[HZ_FAULT]    = stat_is_fault(mem_status) || stat_is_fault(wb_status);
    end

    assign exe_alu = (exe_op == OP_ALU);

endmodule

// File: rtl/hzc_action.sv
// Action mapper: converts hazard causes into per-stage stall and bubble
// controls. A stall request on a stage suppresses a bubble request on the
// same stage, which gives load/use priority over return handling in D.
module hzc_action
    import hzc_pkg::*;
(
    input  logic [HZ_N-1:0]  cause,
    input  logic             exe_alu,
    output logic [STG_N-1:0] stall_o,
    output logic [STG_N-1:0] bubble_o,
    output logic             cc_en_o
);

    for (genvar s = 0; s < STG_N; s++) begin : g_stage
        logic stall_req;
        logic bub_req;

        // Gather the requests that target this stage.
        always_comb begin
            stall_req = |(cause & stall_mask(s));
            bub_req   = |(cause & bubble_mask(s));
        end

        assign stall_o[s]  = stall_req;
        assign bubble_o[s] = bub_req & ~stall_req;
    end

    // Condition codes may change only for an ALU op with no fault behind it.
    always_comb begin
        cc_en_o = exe_alu && !cause[HZ_FAULT];
    end

endmodule

// File: rtl/hzc_pipe_reg.sv
// Pipeline register with normal, stall and bubble modes.
// Assumes stall and bubble are not both requested; if they are, stall wins.
// Synchronous active-low reset loads the no-op value.
module hzc_pipe_reg #(
    parameter int           W       = 8,
    parameter logic [W-1:0] NOP_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stall,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Update the stored value according to the requested mode.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= NOP_VAL;
        else if (stall)  q <= q;
        else if (bubble) q <= NOP_VAL;
        else             q <= d;
    end

endmodule

// File: rtl/hzc_stage_ctl.sv
// Top of the stage controller: detector followed by the action mapper.
// Purely combinational; outputs are meant to be used at the coming clock edge.
module hzc_stage_ctl
    import hzc_pkg::*;
#(
    parameter int             IW       = 4,
    parameter int             RW       = 4,
    parameter logic [IW-1:0]  OP_LOAD  = 'h5,
    parameter logic [IW-1:0]  OP_POP   = 'hB,
    parameter logic [IW-1:0]  OP_RET   = 'h9,
    parameter logic [IW-1:0]  OP_JMP   = 'h7,
    parameter logic [IW-1:0]  OP_ALU   = 'h6,
    parameter logic [RW-1:0]  REG_NONE = '1
) (
    input  logic [IW-1:0]    dec_op,
    input  logic [IW-1:0]    exe_op,
    input  logic [IW-1:0]    mem_op,
    input  logic [RW-1:0]    exe_ld_dst,
    input  logic [RW-1:0]    dec_src_a,
    input  logic [RW-1:0]    dec_src_b,
    input  logic             exe_cond_ok,
    input  logic [1:0]       mem_status,
    input  logic [1:0]       wb_status,
    output logic [STG_N-1:0] stage_stall,
    output logic [STG_N-1:0] stage_bubble,
    output logic             cc_wr_en
);

    logic [HZ_N-1:0] cause;
    logic            exe_alu;

    hzc_detect #(
        .IW(IW), .RW(RW),
        .OP_LOAD(OP_LOAD), .OP_POP(OP_POP), .OP_RET(OP_RET),
        .OP_JMP(OP_JMP), .OP_ALU(OP_ALU), .REG_NONE(REG_NONE)
    ) u_detect (
        .dec_op      (dec_op),
        .exe_op      (exe_op),
        .mem_op      (mem_op),
        .exe_ld_dst  (exe_ld_dst),
        .dec_src_a   (dec_src_a),
        .dec_src_b   (dec_src_b),
        .exe_cond_ok (exe_cond_ok),
        .mem_status  (mem_status),
        .wb_status   (wb_status),
        .cause       (cause),
        .exe_alu     (exe_alu)
    );

    hzc_action u_action (
        .cause    (cause),
        .exe_alu  (exe_alu),
        .stall_o  (stage_stall),
        .bubble_o (stage_bubble),
        .cc_en_o  (cc_wr_en)
    );

endmodule

// File: rtl/hzc_stage_ctl_chk.sv
// Checker for the stage controller, bound to every instance of the top.
// Relates input conditions to the control outputs on every evaluation.
module hzc_stage_ctl_chk
    import hzc_pkg::*;
#(
    parameter int             IW       = 4,
    parameter int             RW       = 4,
    parameter logic [IW-1:0]  OP_LOAD  = 'h5,
    parameter logic [IW-1:0]  OP_POP   = 'hB,
    parameter logic [IW-1:0]  OP_RET   = 'h9,
    parameter logic [IW-1:0]  OP_JMP   = 'h7,
    parameter logic [IW-1:0]  OP_ALU   = 'h6,
    parameter logic [RW-1:0]  REG_NONE = '1
) (
    input logic [IW-1:0]    dec_op,
    input logic [IW-1:0]    exe_op,
    input logic [IW-1:0]    mem_op,
    input logic [RW-1:0]    exe_ld_dst,
    input logic [RW-1:0]    dec_src_a,
    input logic [RW-1:0]    dec_src_b,
    input logic             exe_cond_ok,
    input logic [1:0]       mem_status,
    input logic [1:0]       wb_status,
    input logic [STG_N-1:0] stage_stall,
    input logic [STG_N-1:0] stage_bubble,
    input logic             cc_wr_en
);

    logic lu_seen;
    logic ret_seen;
    logic mis_seen;
    logic flt_seen;

    // Conditions as observed at the ports.
    always_comb begin
        lu_seen  = ((exe_op == OP_LOAD) || (exe_op == OP_POP)) &&
                   (exe_ld_dst != REG_NONE) &&
                   ((exe_ld_dst == dec_src_a) || (exe_ld_dst == dec_src_b));
        ret_seen = (dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET);
        mis_seen = (exe_op == OP_JMP) && !exe_cond_ok;
        flt_seen = (mem_status != ST_OK) || (wb_status != ST_OK);
    end

    // Output relations that must hold at all times.
    always_comb begin
        AST_NO_DUAL_CTRL: assert ((stage_stall & stage_bubble) == '0)
            else $error("stall and bubble on one stage"); // R10
        AST_LOAD_USE_ACT: assert (!lu_seen || (stage_stall[STG_F] && stage_stall[STG_D] && stage_bubble[STG_E]))
            else $error("load/use action missing"); // R1
        AST_NULL_DST_QUIET: assert (!(exe_ld_dst == REG_NONE) || !stage_stall[STG_D])
            else $error("null destination stalled decode"); // R2
        AST_RET_ACT: assert (!(ret_seen && !lu_seen) || (stage_stall[STG_F] && stage_bubble[STG_D]))
            else $error("return action missing"); // R3
        AST_MISPRED_ACT: assert (!mis_seen || (stage_bubble[STG_D] && stage_bubble[STG_E]))
            else $error("misprediction action missing"); // R4
        AST_FAULT_ACT: assert (!flt_seen || (stage_bubble[STG_M] && stage_stall[STG_W]))
            else $error("fault action missing"); // R5
        AST_CC_GATED: assert (!cc_wr_en || (!flt_seen && exe_op == OP_ALU))
            else $error("condition codes enabled illegally"); // R6
        AST_LU_OVER_RET: assert (!(lu_seen && ret_seen) || !stage_bubble[STG_D])
            else $error("decode bubbled during load/use"); // R7
        AST_UNUSED_LOW: assert (!stage_stall[STG_E] && !stage_stall[STG_M] &&
                                !stage_bubble[STG_F] && !stage_bubble[STG_W])
            else $error("unused control line asserted"); // R9
    end

endmodule

bind hzc_stage_ctl hzc_stage_ctl_chk #(
    .IW(IW), .RW(RW),
    .OP_LOAD(OP_LOAD), .OP_POP(OP_POP), .OP_RET(OP_RET),
    .OP_JMP(OP_JMP), .OP_ALU(OP_ALU), .REG_NONE(REG_NONE)
) u_chk (.*);

// File: tb/tb_hzc_stage_ctl.sv
// Self-checking bench: behavioural reference compared every clock.
module tb_hzc_stage_ctl;

    logic clk = 1'b0;
    always #10 clk = ~clk; // 50 MHz

    logic [3:0] dec_op, exe_op, mem_op;
    logic [3:0] exe_ld_dst, dec_src_a, dec_src_b;
    logic       exe_cond_ok;
    logic [1:0] mem_status, wb_status;
    logic [4:0] stage_stall, stage_bubble;
    logic       cc_wr_en;

    logic       rst_n;
    logic       pr_stall, pr_bubble;
    logic [7:0] pr_d, pr_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    hzc_stage_ctl dut (
        .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op),
        .exe_ld_dst(exe_ld_dst), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_cond_ok(exe_cond_ok), .mem_status(mem_status), .wb_status(wb_status),
        .stage_stall(stage_stall), .stage_bubble(stage_bubble), .cc_wr_en(cc_wr_en)
    );

    hzc_pipe_reg #(.W(8), .NOP_VAL(8'h10)) u_preg (
        .clk(clk), .rst_n(rst_n), .stall(pr_stall), .bubble(pr_bubble),
        .d(pr_d), .q(pr_q)
    );

    // Reference: expected controls from the requirement text.
    task automatic ref_ctl(output logic [4:0] est, output logic [4:0] ebb,
                           output logic ecc, output string tag);
        int op_e, op_d, op_m;
        bit lu, rt, mp, ft;
        op_e = int'(exe_op); op_d = int'(dec_op); op_m = int'(mem_op);
        lu = (op_e == 5 || op_e == 11) && exe_ld_dst != 4'hF &&
             (exe_ld_dst == dec_src_a || exe_ld_dst == dec_src_b);
        rt = (op_d == 9) || (op_e == 9) || (op_m == 9);
        mp = (op_e == 7) && !exe_cond_ok;
        ft = (mem_status != 0) || (wb_status != 0);
        est = '0; ebb = '0;
        if (lu || rt) est[0] = 1'b1;
        if (lu)       est[1] = 1'b1;
        if (ft)       est[4] = 1'b1;
        if ((rt || mp) && !lu) ebb[1] = 1'b1;
        if (lu || mp) ebb[2] = 1'b1;
        if (ft)       ebb[3] = 1'b1;
        ecc = (op_e == 6) && !ft;
        if (lu && rt)      tag = "R7";
        else if (mp && rt) tag = "R8";
        else if (ft)       tag = "R5";
        else if (lu)       tag = "R1";
        else if (rt)       tag = "R3";
        else if (mp)       tag = "R4";
        else if (op_e == 6) tag = "R6";
        else               tag = "R9";
    endtask

    task automatic check_ctl(input string req);
        logic [4:0] est, ebb;
        logic ecc;
        string t;
        ref_ctl(est, ebb, ecc, t);
        if (req == "") req = t;
        n_chk++;
        if (stage_stall !== est || stage_bubble !== ebb || cc_wr_en !== ecc) begin
            n_fail++;
            $display("FAIL %s: stall=%b bubble=%b cc=%b expected stall=%b bubble=%b cc=%b",
                     req, stage_stall, stage_bubble, cc_wr_en, est, ebb, ecc);
        end
    endtask

    // Drive one input pattern at the falling edge, check mid-low-phase.
    task automatic apply(input logic [3:0] d_op, input logic [3:0] e_op, input logic [3:0] m_op,
                         input logic [3:0] dst, input logic [3:0] sa, input logic [3:0] sb,
                         input logic cond, input logic [1:0] ms, input logic [1:0] ws,
                         input string req);
        @(negedge clk);
        dec_op = d_op; exe_op = e_op; mem_op = m_op;
        exe_ld_dst = dst; dec_src_a = sa; dec_src_b = sb;
        exe_cond_ok = cond; mem_status = ms; wb_status = ws;
        #5;
        check_ctl(req);
    endtask

    task automatic check_reg(input logic [7:0] exp, input string req);
        n_chk++;
        if (pr_q !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%h expected %h", req, pr_q, exp);
        end
    endtask

    task automatic reg_step(input logic r, input logic s, input logic b,
                            input logic [7:0] d, input logic [7:0] exp, input string req);
        @(negedge clk);
        rst_n = r; pr_stall = s; pr_bubble = b; pr_d = d;
        @(posedge clk);
        #5;
        check_reg(exp, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        dec_op = 4'h1; exe_op = 4'h1; mem_op = 4'h1;
        exe_ld_dst = 4'hF; dec_src_a = 4'hF; dec_src_b = 4'hF;
        exe_cond_ok = 1'b1; mem_status = 2'd0; wb_status = 2'd0;
        rst_n = 1'b0; pr_stall = 1'b0; pr_bubble = 1'b0; pr_d = 8'h00;

        // pipeline register
        reg_step(1'b0, 1'b0, 1'b0, 8'hA5, 8'h10, "R13");
        reg_step(1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, "R11");
        reg_step(1'b1, 1'b1, 1'b0, 8'h77, 8'h3C, "R12");
        reg_step(1'b1, 1'b0, 1'b1, 8'h88, 8'h10, "R12");
        reg_step(1'b1, 1'b0, 1'b0, 8'h5A, 8'h5A, "R11");
        reg_step(1'b1, 1'b1, 1'b1, 8'h99, 8'h5A, "R12");
        reg_step(1'b0, 1'b1, 1'b0, 8'h99, 8'h10, "R13");

        // controller: idle
        apply(4'h1, 4'h1, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R9");
        // load/use
        apply(4'h6, 4'h5, 4'h1, 4'h3, 4'h3, 4'h0, 1'b1, 2'd0, 2'd0, "R1");
        apply(4'h6, 4'hB, 4'h1, 4'h4, 4'h2, 4'h4, 1'b1, 2'd0, 2'd0, "R1");
        apply(4'h6, 4'h5, 4'h1, 4'h3, 4'h2, 4'h4, 1'b1, 2'd0, 2'd0, "R1");
        apply(4'h6, 4'h6, 4'h1, 4'h3, 4'h3, 4'h3, 1'b1, 2'd0, 2'd0, "R1");
        apply(4'h6, 4'h5, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R2");
        apply(4'h6, 4'hB, 4'h1, 4'hF, 4'h1, 4'hF, 1'b1, 2'd0, 2'd0, "R2");
        // returns
        apply(4'h9, 4'h1, 4'h1, 4'hF, 4'h4, 4'hF, 1'b1, 2'd0, 2'd0, "R3");
        apply(4'h1, 4'h9, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R3");
        apply(4'h1, 4'h1, 4'h9, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R3");
        // jumps
        apply(4'h1, 4'h7, 4'h1, 4'hF, 4'hF, 4'hF, 1'b0, 2'd0, 2'd0, "R4");
        apply(4'h1, 4'h7, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R4");
        // faults
        for (int s = 1; s < 4; s++) begin
            apply(4'h1, 4'h6, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'(s), 2'd0, "R5");
            apply(4'h1, 4'h6, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'(s), "R5");
        end
        // condition codes
        apply(4'h1, 4'h6, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R6");
        apply(4'h1, 4'h6, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd3, 2'd0, "R6");
        apply(4'h1, 4'h2, 4'h1, 4'hF, 4'hF, 4'hF, 1'b1, 2'd0, 2'd0, "R6");
        // combinations
        apply(4'h9, 4'h5, 4'h1, 4'h4, 4'h4, 4'hF, 1'b1, 2'd0, 2'd0, "R7");
        apply(4'h9, 4'hB, 4'h1, 4'h4, 4'hF, 4'h4, 1'b1, 2'd2, 2'd0, "R7");
        apply(4'h9, 4'h7, 4'h1, 4'hF, 4'hF, 4'hF, 1'b0, 2'd0, 2'd0, "R8");
        apply(4'h9, 4'h7, 4'h1, 4'hF, 4'hF, 4'hF, 1'b0, 2'd0, 2'd1, "R8");

        // randomised patterns, tagged by the dominant condition (R10 throughout)
        for (int i = 0; i < 600; i++) begin
            logic [3:0] pick [6];
            logic [3:0] ops [3];
            logic [3:0] dst;
            pick[0] = 4'h1; pick[1] = 4'h5; pick[2] = 4'h6;
            pick[3] = 4'h7; pick[4] = 4'h9; pick[5] = 4'hB;
            for (int k = 0; k < 3; k++) begin
                if (($urandom % 4) == 0) ops[k] = 4'($urandom);
                else                     ops[k] = pick[$urandom % 6];
            end
            dst = (($urandom % 5) == 0) ? 4'hF : 4'($urandom % 8);
            apply(ops[0], ops[1], ops[2], dst,
                  (($urandom % 3) == 0) ? dst : 4'($urandom),
                  4'($urandom),
                  1'($urandom),
                  (($urandom % 4) == 0) ? 2'($urandom) : 2'd0,
                  (($urandom % 4) == 0) ? 2'($urandom) : 2'd0,
                  "");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule